// File: doc/BRIEF.md
# Open-Drain Bus Clock Generator

This block drives the clock wire of a two-wire serial bus that uses open-drain signalling. It never drives the wire high. Its only drive output is a pull-low enable, and when that enable is released an external pull-up brings the wire high. The block also receives the sampled wire level and one-cycle pulses that mark each rising and falling edge seen on the wire. It uses these to time every level from the moment the level actually appears on the bus. Because of this, a level that another device stretches is measured from the point where it really ends.

A controller selects the mode with three request inputs. One request runs the clock freely. One asks for a single falling transition, and the other asks for a single rising transition. When a rise is requested but some other device holds the wire low, the block raises a blocked flag and keeps its own enable released until the wire goes high or the request is withdrawn. A parameter sets the minimum number of system clock cycles that each level must last.

Top module: `odclk_gen`

## Requirements
- R1: A synchronous active-high reset drives `pull_low_o` and `blocked_o` to 0 at the next clock edge. The stable-time counter also restarts from zero.
- R2: While no request is asserted, `pull_low_o` keeps its value. After reset, with no request, the enable is 0 and the wire reads high.
- R3: `pull_low_o` changes only at a clock edge where HOLD_CYC full cycles have passed since the last edge pulse on `rise_seen_i` or `fall_seen_i` and since its own last change. A request made just after an observed edge therefore waits HOLD_CYC+1 edges.
- R4: While the falling request is in effect, the enable goes to 1 once the stable time has passed and never returns to 0. The enable stays 1 after the request is withdrawn.
- R5: While the rising request is in effect, the enable goes to 0 once the stable time has passed and never returns to 1. The wire stays high after the request is withdrawn.
- R6: While the run request is held, the enable alternates. When the wire loops back and each edge pulse arrives one cycle after the enable moves, every level lasts exactly HOLD_CYC+2 cycles.
- R7: Suppose the rising request is in effect, the enable is 0 and the wire reads low. Then `blocked_o` is 1 after the next clock edge.
- R8: Whenever `blocked_o` is 1, `pull_low_o` is 0.
- R9: `blocked_o` returns to 0 at the edge after the wire reads high or the rising request stops being in effect.
- R10: When requests overlap, run outranks falling, and falling outranks rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| line_i | input | 1 | Sampled level of the bus clock wire (1 = high) |
| rise_seen_i | input | 1 | One-cycle pulse: rising edge observed on the wire |
| fall_seen_i | input | 1 | One-cycle pulse: falling edge observed on the wire |
| req_run_i | input | 1 | Request free-running clocking |
| req_low_i | input | 1 | Request a single transition to low |
| req_high_i | input | 1 | Request a single transition to high |
| pull_low_o | output | 1 | Enable for the open-drain pull-down on the wire |
| blocked_o | output | 1 | Requested rise is held off by an external low |

## Verification
The bound checker watches these properties on every cycle: the enable holds when no request is active, no change happens before the wire has been stable for the full hold time, one-shot modes never reverse, and the blocked flag sets, clears and excludes the pull-down as specified. Some behaviour needs a bus model wrapped around the block, and only the bench scenarios can show it. This covers the exact level length in free-running mode, the priority between overlapping requests, the delayed response to a request made just after an edge, and the reset of a block that is pulling low or blocked.

// File: rtl/odclk_pkg.sv
package odclk_pkg;
  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_RUN  = 2'd1,
    M_LOW  = 2'd2,
    M_HIGH = 2'd3
  } mode_t;
endpackage

// File: rtl/odclk_arb.sv
module odclk_arb
  import odclk_pkg::*;
(
  input  logic  req_run_i,
  input  logic  req_low_i,
  input  logic  req_high_i,
  output mode_t mode_o
);
  // run > low > high
  always_comb begin
    if (req_run_i)       mode_o = M_RUN;
    else if (req_low_i)  mode_o = M_LOW;
    else if (req_high_i) mode_o = M_HIGH;
    else                 mode_o = M_IDLE;
  end
endmodule

// File: rtl/odclk_timer.sv
module odclk_timer #(
  parameter int HOLD_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic rise_seen_i,
  input  logic fall_seen_i,
  input  logic restart_i,
  output logic ready_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;

  assign ready_o = (cnt_q == LIM);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (rise_seen_i || fall_seen_i || restart_i)
      cnt_q <= '0;
    else if (!ready_o)
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/odclk_drv.sv
module odclk_drv
  import odclk_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_t mode_i,
  input  logic  ready_i,
  input  logic  line_i,
  output logic  change_o,
  output logic  pull_low_o,
  output logic  blocked_o
);
  logic pull_d;

  always_comb begin
    pull_d = pull_low_o;
    unique case (mode_i)
      M_RUN:   if (ready_i) pull_d = line_i;
      M_LOW:   if (ready_i) pull_d = 1'b1;
      M_HIGH:  if (ready_i) pull_d = 1'b0;
      default: pull_d = pull_low_o;
    endcase
  end

  assign change_o = (pull_d != pull_low_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      pull_low_o <= 1'b0;
      blocked_o  <= 1'b0;
    end else begin
      pull_low_o <= pull_d;
      blocked_o  <= (mode_i == M_HIGH) && !pull_low_o && !line_i;
    end
  end
endmodule

// File: rtl/odclk_gen.sv
module odclk_gen
  import odclk_pkg::*;
#(
  parameter int HOLD_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic rise_seen_i,
  input  logic fall_seen_i,
  input  logic req_run_i,
  input  logic req_low_i,
  input  logic req_high_i,
  output logic pull_low_o,
  output logic blocked_o
);
  mode_t mode;
  logic  ready;
  logic  change;

  odclk_arb u_arb (
    .req_run_i  (req_run_i),
    .req_low_i  (req_low_i),
    .req_high_i (req_high_i),
    .mode_o     (mode)
  );

  odclk_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .rise_seen_i (rise_seen_i),
    .fall_seen_i (fall_seen_i),
    .restart_i   (change),
    .ready_o     (ready)
  );

  odclk_drv u_drv (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode),
    .ready_i    (ready),
    .line_i     (line_i),
    .change_o   (change),
    .pull_low_o (pull_low_o),
    .blocked_o  (blocked_o)
  );
endmodule

// File: rtl/odclk_gen_chk.sv
module odclk_gen_chk #(
  parameter int HOLD_CYC = 5
) (
  input logic clk,
  input logic rst,
  input logic line_i,
  input logic rise_seen_i,
  input logic fall_seen_i,
  input logic req_run_i,
  input logic req_low_i,
  input logic req_high_i,
  input logic pull_low_o,
  input logic blocked_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(HOLD_CYC);

  logic [CW-1:0] gap_q;
  logic idle, hi_eff, lo_eff;

  assign idle   = !req_run_i && !req_low_i && !req_high_i;
  assign hi_eff = !req_run_i && !req_low_i && req_high_i;
  assign lo_eff = !req_run_i && req_low_i;

  // cycles since the last observed wire edge, saturating
  always_ff @(posedge clk) begin
    if (rst)                            gap_q <= '0;
    else if (rise_seen_i || fall_seen_i) gap_q <= '0;
    else if (gap_q != LIM)              gap_q <= gap_q + 1'b1;
  end

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    idle |=> $stable(pull_low_o));

  p_stable_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (!$stable(pull_low_o) && !$past(rst)) |-> ($past(gap_q) == LIM));

  p_low_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    (lo_eff && pull_low_o) |=> pull_low_o);

  p_high_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    (hi_eff && !pull_low_o) |=> !pull_low_o);

  p_blk_set_r7: assert property (@(posedge clk) disable iff (rst)
    (hi_eff && !pull_low_o && !line_i) |=> blocked_o);

  p_blk_release_r8: assert property (@(posedge clk) disable iff (rst)
    blocked_o |-> !pull_low_o);

  p_blk_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (line_i || !hi_eff) |=> !blocked_o);
endmodule

bind odclk_gen odclk_gen_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .line_i      (line_i),
  .rise_seen_i (rise_seen_i),
  .fall_seen_i (fall_seen_i),
  .req_run_i   (req_run_i),
  .req_low_i   (req_low_i),
  .req_high_i  (req_high_i),
  .pull_low_o  (pull_low_o),
  .blocked_o   (blocked_o)
);

// File: tb/odclk_gen_test.sv
module odclk_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 5;
  localparam int LVL  = HOLD + 2;
  localparam int NV   = 17;

  typedef struct packed {
    logic       run;
    logic       low;
    logic       high;
    logic       ext;
    logic [4:0] wait_n;
    logic       exp_pull;
    logic       exp_blk;
    logic [3:0] req;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0, 5'd10, 1'b0,1'b0, 4'd2 },  // R2 idle after reset
    '{1'b0,1'b1,1'b0,1'b0, 5'd1,  1'b1,1'b0, 4'd4 },  // R4 fall
    '{1'b0,1'b0,1'b0,1'b0, 5'd20, 1'b1,1'b0, 4'd4 },  // R4 stays low
    '{1'b0,1'b0,1'b1,1'b0, 5'd1,  1'b0,1'b0, 4'd5 },  // R5 rise
    '{1'b0,1'b0,1'b0,1'b0, 5'd20, 1'b0,1'b0, 4'd5 },  // R5 stays high
    '{1'b0,1'b0,1'b0,1'b1, 5'd3,  1'b0,1'b0, 4'd7 },  // R7 ext low, no request
    '{1'b0,1'b0,1'b1,1'b1, 5'd2,  1'b0,1'b1, 4'd7 },  // R7 blocked
    '{1'b0,1'b0,1'b1,1'b1, 5'd10, 1'b0,1'b1, 4'd8 },  // R8 enable off while blocked
    '{1'b0,1'b0,1'b0,1'b1, 5'd1,  1'b0,1'b0, 4'd9 },  // R9 request withdrawn
    '{1'b0,1'b0,1'b1,1'b1, 5'd2,  1'b0,1'b1, 4'd7 },  // R7 blocked again
    '{1'b0,1'b0,1'b1,1'b0, 5'd1,  1'b0,1'b0, 4'd9 },  // R9 wire released
    '{1'b0,1'b1,1'b0,1'b0, 5'd5,  1'b0,1'b0, 4'd3 },  // R3 too soon after edge
    '{1'b0,1'b1,1'b0,1'b0, 5'd1,  1'b1,1'b0, 4'd3 },  // R3 now allowed
    '{1'b0,1'b0,1'b0,1'b0, 5'd10, 1'b1,1'b0, 4'd2 },  // R2 hold low
    '{1'b0,1'b1,1'b1,1'b0, 5'd1,  1'b1,1'b0, 4'd10},  // R10 fall beats rise
    '{1'b1,1'b1,1'b1,1'b0, 5'd1,  1'b0,1'b0, 4'd10},  // R10 run beats fall
    '{1'b0,1'b0,1'b0,1'b0, 5'd1,  1'b0,1'b0, 4'd2 }   // R2 hold high
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_run = 1'b0, req_low = 1'b0, req_high = 1'b0, ext_low = 1'b0;
  logic pull_low, blocked;
  logic bus_line, prev_line = 1'b1;
  logic rise_seen, fall_seen;
  int   n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // open-drain wire with pull-up and an edge observer
  assign bus_line  = !(pull_low || ext_low);
  always_ff @(posedge clk) prev_line <= bus_line;
  assign rise_seen = bus_line && !prev_line;
  assign fall_seen = !bus_line && prev_line;

  odclk_gen #(.HOLD_CYC(HOLD)) uut (
    .clk         (clk),
    .rst         (rst),
    .line_i      (bus_line),
    .rise_seen_i (rise_seen),
    .fall_seen_i (fall_seen),
    .req_run_i   (req_run),
    .req_low_i   (req_low),
    .req_high_i  (req_high),
    .pull_low_o  (pull_low),
    .blocked_o   (blocked)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(input logic lvl, output int n);
    n = 0;
    while (pull_low == lvl && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int len;
    int w;
    repeat (3) @(negedge clk);
    chk("R1 reset pull_low", pull_low, 0);
    chk("R1 reset blocked", blocked, 0);
    chk("R2 wire high after reset", bus_line, 1);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      req_run  = TBL[i].run;
      req_low  = TBL[i].low;
      req_high = TBL[i].high;
      ext_low  = TBL[i].ext;
      repeat (int'(TBL[i].wait_n)) @(negedge clk);
      chk($sformatf("R%0d row %0d pull_low", TBL[i].req, i), pull_low, TBL[i].exp_pull);
      chk($sformatf("R%0d row %0d blocked", TBL[i].req, i), blocked, TBL[i].exp_blk);
    end

    // R6: free-running level lengths
    req_run = 1'b0; req_low = 1'b0; req_high = 1'b0; ext_low = 1'b0;
    repeat (10) @(negedge clk);
    req_run = 1'b1;
    w = 0;
    while (!pull_low && w < 50) begin
      @(negedge clk);
      w++;
    end
    for (int p = 0; p < 2; p++) begin
      measure(1'b1, len);
      chk("R6 low level length", len, LVL);
      measure(1'b0, len);
      chk("R6 high level length", len, LVL);
    end
    req_run = 1'b0;
    repeat (2 * LVL) @(negedge clk);

    // R1: reset while pulling low
    req_low = 1'b1;
    repeat (2 * LVL) @(negedge clk);
    chk("R4 pulled low before reset", pull_low, 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset clears pull_low", pull_low, 0);
    rst = 1'b0;
    req_low = 1'b0;
    repeat (2 * LVL) @(negedge clk);

    // R1: reset while blocked
    ext_low = 1'b1;
    req_high = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 blocked before reset", blocked, 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset clears blocked", blocked, 0);
    rst = 1'b0;
    req_high = 1'b0;
    ext_low = 1'b0;
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule